// File: doc/BRIEF.md
# Reloadable Watchdog Timer with Safe-State Trigger

This block is a host-serviced countdown watchdog for a relay control card. Software writes a 16-bit timeout value, which lands in the down-counter at once. Software then sets the enable bit in the control word. A prescaler divides the system clock into ticks of about 1/2048 s, and each tick takes one from the counter. With the default divider of 4028 at 8.25 MHz, a timeout runs from roughly 0.5 ms up to 32 s.

To keep the watchdog from firing, software must write a fresh value before the count runs out. If the count is allowed to expire, the block does three things:
- it latches a sticky overflow flag;
- it raises the watchdog interrupt status;
- it sends a single-cycle request to the emergency path, which drives the relays to their safe pattern, unless emergency handling is turned off.

Counting only restarts after two steps in order. Software first reloads the counter, which clears the overflow. It then writes the interrupt-clear bit. A clear that arrives before the reload is ignored.

Top module: `wdt_safe_trigger`

## Requirements
- R1: After reset the count is 0, the watchdog is disabled, and the overflow, interrupt and emergency request outputs are all low.
- R2: A load write places `load_val` in the counter on the next cycle, clears the overflow flag and restarts the prescaler from zero, so the next tick comes a full PRESCALE cycles after the load.
- R3: While the enable bit (control bit 15) is 0, the count and the prescaler hold their values.
- R4: When enabled, with no overflow and no pending interrupt, the count drops by one every PRESCALE cycles. With a load value N ≥ 1, overflow is set exactly N×PRESCALE cycles after the later of the load write and the start of counting.
- R5: A load value of zero overflows on the first tick, PRESCALE cycles after counting starts.
- R6: On overflow the count reads 0, and the overflow flag and interrupt status both go high and stay high. No further counting happens.
- R7: The emergency request is high for exactly one cycle, on the cycle the block enters overflow, and only if `emg_enable` is high. Otherwise it never rises.
- R8: A control write with the clear bit (bit 7) set has no effect on the interrupt while the overflow flag is still set.
- R9: After a reload, a clear write drops the interrupt. Counting resumes from that write, and the next overflow comes N×PRESCALE cycles later.
- R10: Reloading before expiry, at intervals shorter than the timeout, keeps overflow from ever being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_we | input | 1 | Write strobe for the timeout value |
| load_val | input | CNT_W | Timeout value in ticks |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | CTRL_W | Control word: bit 15 enable, bit 7 interrupt clear |
| emg_enable | input | 1 | Emergency path enabled |
| count_o | output | CNT_W | Current counter value |
| overflow_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Watchdog interrupt status |
| emg_req_o | output | 1 | One-cycle emergency safe-state request |

## Verification
The bench sweeps every load value from 0 to 10 and checks the counter, the overflow flag and the emergency request on every cycle against arithmetic on the prescale. This catches a design that counts one tick too many or too few, or that treats zero as a full wrap rather than as an immediate expiry.

It also tries the clear write while the overflow flag is still set. A design that does not lock out this early clear would drop the interrupt without any reload. It then checks that counting stays frozen after the reload until the clear arrives.

A load written halfway through a prescale period shows whether the prescaler restarts on load; a design that does not restart it fires early. Repeated service reloads show that a serviced watchdog never trips. Sweeping with emergency handling both on and off shows whether the request is held high or leaks through when it should be masked.

// File: rtl/wdt_safe_trigger.sv
module wdt_safe_trigger #(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 4028,
  parameter int CTRL_W   = 16,
  parameter int EN_BIT   = 15,
  parameter int CLR_BIT  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  input  logic             ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic             emg_enable,
  output logic [CNT_W-1:0] count_o,
  output logic             overflow_o,
  output logic             irq_o,
  output logic             emg_req_o
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PS_W-1:0]  presc;
  logic [CNT_W-1:0] cnt;
  logic             en, ovf, irq, emg_q;

  wire running = en & ~ovf & ~irq;
  wire tick    = running & (presc == PS_W'(PRESCALE - 1));
  wire expire  = tick & ~load_we & (cnt <= CNT_W'(1));
  wire clr_ok  = ctrl_we & ctrl_wdata[CLR_BIT] & ~ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      cnt   <= '0;
      en    <= 1'b0;
      ovf   <= 1'b0;
      irq   <= 1'b0;
      emg_q <= 1'b0;
    end else begin
      if (ctrl_we) en <= ctrl_wdata[EN_BIT];
      if (load_we) begin
        cnt   <= load_val;
        ovf   <= 1'b0;
        presc <= '0;
      end else if (running) begin
        presc <= tick ? '0 : presc + 1'b1;
        if (tick) begin
          cnt <= expire ? '0 : cnt - 1'b1;
          if (expire) ovf <= 1'b1;
        end
      end
      if (expire)      irq <= 1'b1;
      else if (clr_ok) irq <= 1'b0;
      emg_q <= expire & emg_enable;
    end
  end

  assign count_o    = cnt;
  assign overflow_o = ovf;
  assign irq_o      = irq;
  assign emg_req_o  = emg_q;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> (count_o == $past(load_val)) && !overflow_o);
  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load_we) |=> $stable(count_o));
  p_ovf_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_o) |-> irq_o && (count_o == '0));
  p_ovf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !load_we) |=> overflow_o && $stable(count_o));
  p_emg_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    emg_req_o |=> !emg_req_o);
  p_emg_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    emg_req_o |-> overflow_o && $past(emg_enable));
  p_clr_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && overflow_o) |=> irq_o);
endmodule

// File: tb/tb_wdt_safe_trigger.sv
module tb_wdt_safe_trigger;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int P = 4;

  logic clk = 0, rst_n = 0;
  logic load_we = 0, ctrl_we = 0, emg_enable = 0;
  logic [W-1:0] load_val = '0;
  logic [15:0] ctrl_wdata = '0;
  logic [W-1:0] count_o;
  logic overflow_o, irq_o, emg_req_o;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_safe_trigger #(.CNT_W(W), .PRESCALE(P)) dut (
    .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_val(load_val),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .emg_enable(emg_enable),
    .count_o(count_o), .overflow_o(overflow_o), .irq_o(irq_o), .emg_req_o(emg_req_o));

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_load(input int v);
    @(negedge clk); load_we = 1; load_val = W'(v);
    @(negedge clk); load_we = 0;
  endtask

  task automatic do_ctrl(input bit en, input bit clr);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = '0;
    ctrl_wdata[15] = en; ctrl_wdata[7] = clr;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_cyc(3);
    // R1 reset state
    chk(count_o, 0, "R1 count"); chk(overflow_o, 0, "R1 ovf");
    chk(irq_o, 0, "R1 irq");     chk(emg_req_o, 0, "R1 emg");
    rst_n = 1;
    wait_cyc(2);

    // R2 load, R3 disabled hold
    do_load(5);
    chk(count_o, 5, "R2 load value");
    wait_cyc(30);
    chk(count_o, 5, "R3 hold while disabled");
    chk(overflow_o, 0, "R3 no overflow while disabled");

    // R4/R5/R6/R7 sweep of load values
    for (int n = 0; n <= 10; n++) begin
      int lim;
      emg_enable = n[0];
      do_ctrl(0, 0);
      do_load(n);
      do_ctrl(0, 1);
      chk(irq_o, 0, "R9 clear after reload");
      do_ctrl(1, 0);
      lim = ((n == 0) ? 1 : n) * P;
      for (int k = 0; k <= lim + 1; k++) begin
        int ce;
        ce = (k >= lim) ? 0 : n - k / P;
        chk(count_o, ce, (n == 0) ? "R5 count" : "R4 count");
        chk(overflow_o, (k >= lim) ? 1 : 0, (n == 0) ? "R5 overflow timing" : "R4 overflow timing");
        chk(emg_req_o, (k == lim && n[0]) ? 1 : 0, "R7 emergency pulse");
        if (k == lim) chk(irq_o, 1, "R6 irq on overflow");
        @(negedge clk);
      end
      wait_cyc(10);
      chk(overflow_o, 1, "R6 overflow sticky");
      chk(irq_o, 1, "R6 irq sticky");
      chk(count_o, 0, "R6 count held");
      chk(emg_req_o, 0, "R7 no repeat pulse");
    end

    // R8 clear ignored while overflow still set
    do_ctrl(1, 1);
    chk(irq_o, 1, "R8 clear ignored before reload");
    chk(overflow_o, 1, "R8 overflow kept");

    // R9 reload then clear resumes counting
    do_load(3);
    chk(overflow_o, 0, "R9 reload clears overflow");
    chk(irq_o, 1, "R9 irq held after reload");
    wait_cyc(20);
    chk(count_o, 3, "R9 frozen until clear");
    do_ctrl(1, 1);
    chk(irq_o, 0, "R9 clear after reload");
    wait_cyc(3 * P - 1);
    chk(overflow_o, 0, "R9 no early overflow");
    wait_cyc(1);
    chk(overflow_o, 1, "R9 overflow after resume");
    chk(irq_o, 1, "R9 irq after resume");

    // R10 periodic service reload
    do_load(4);
    do_ctrl(1, 1);
    for (int r = 0; r < 8; r++) begin
      wait_cyc(3 * P);
      chk(overflow_o, 0, "R10 serviced no overflow");
      do_load(4);
    end
    chk(count_o, 4, "R10 count after service");

    // R2 prescaler restart on mid-period load
    wait_cyc(P + 2);
    do_load(2);
    wait_cyc(2 * P - 1);
    chk(overflow_o, 0, "R2 prescaler restart no early fire");
    chk(count_o, 1, "R2 prescaler restart count");
    wait_cyc(1);
    chk(overflow_o, 1, "R2 prescaler restart fire");

    // R3 disable mid-count freezes
    do_load(6);
    do_ctrl(1, 1);
    wait_cyc(2 * P);
    do_ctrl(0, 0);
    wait_cyc(5 * P);
    chk(count_o, 4, "R3 frozen mid-count");
    chk(overflow_o, 0, "R3 frozen no overflow");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule